// File: doc/BRIEF.md
# Link Controller Interrupt Status and Enable Registers

This block holds the interrupt state of an infrared link controller. Five event sources deliver single-cycle pulses: frame sent, frame received, transmit FIFO underrun, receive FIFO overflow and serial gap detected. Each pulse sets a sticky status bit. Software reads the status byte, clears the bits it has handled by writing ones to them, and chooses which sources may interrupt through a separate enable byte.

A single level interrupt output is asserted while any status bit has its enable bit set. The output is registered, so it follows the masked status one clock later. The frame-sent event is only counted when the slot that finished asked for a completion notice. That request arrives on a qualifier input that travels with the event pulse.

Register access uses a plain port: a write strobe, an address, write data and combinational read data. The three low bits of both registers are not implemented. They always read back as ones.

Top module: `link_irq_regs`

## Requirements
- R1: After reset all status and enable bits are zero, `irq_o` is low, and both registers read 0x07.
- R2: Status sits at offset 0x0C and enable at offset 0x0D. Both use the same layout: bit 7 frame sent, bit 6 frame received, bit 5 transmit underrun, bit 4 receive overflow, bit 3 serial gap. A one-cycle pulse on an event input sets its status bit on the next clock edge.
- R3: A status bit that is set stays set until software clears it, for any number of idle cycles.
- R4: Writing 1 to a status bit at offset 0x0C clears it. Writing 0 leaves that bit unchanged.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: A write to offset 0x0D loads bits 7:3 of the write data into the enable register. Reading offset 0x0D returns the stored bits.
- R7: Bits 2:0 of both registers read as 1 whatever value was written to them.
- R8: `tx_done_i` sets the frame-sent status bit only when `tx_done_req_i` is high in the same cycle.
- R9: `irq_o` is high one cycle after any status bit is set together with its enable bit. It falls one cycle after the last such pair goes away, whether the status bit was cleared or the enable bit was dropped.
- R10: Writes to offsets other than 0x0C and 0x0D change neither register. Reads of other offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| tx_done_i | input | 1 | Frame sent pulse |
| tx_done_req_i | input | 1 | Finished slot asked for a completion notice |
| rx_done_i | input | 1 | Frame received pulse |
| tx_under_i | input | 1 | Transmit underrun pulse |
| rx_over_i | input | 1 | Receive overflow pulse |
| gap_rcv_i | input | 1 | Serial gap received pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded properties check the following on every cycle:
- event pulses set their bits, including when a clear arrives in the same cycle;
- set bits hold until cleared;
- clearing writes remove only the bits they name;
- enable loads and holds;
- the one-cycle relation between masked status and `irq_o`;
- frame-sent events without a request are rejected;
- writes to unmapped offsets leave the enable byte untouched.

Only the bench scenarios can show the following:
- the actual bit positions and offsets, and the constant ones in bits 2:0 as seen through reads;
- the zero returned by unmapped offsets;
- the exact cycle on which the interrupt rises and falls under a given enable pattern.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_SRC  = 5;
  localparam int SRC_LSB  = REG_W - NUM_SRC;
  localparam logic [SRC_LSB-1:0] PAD_ONES = '1;

  // source index; register bit = index + SRC_LSB
  typedef enum int {
    SRC_GAP   = 0,
    SRC_RXOVR = 1,
    SRC_TXUND = 2,
    SRC_RXDN  = 3,
    SRC_TXDN  = 4
  } src_idx_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_q[i] <= 1'b0;
      else if (set_i[i]) stat_q[i] <= 1'b1;  // event beats clear
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R5
  ev_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));
  // R3
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_o & ~clr_i)) |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));
  // R4
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (load_i) en_q <= data_i;
  end

  assign en_o = en_q;

  // R6
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (en_o == $past(data_i)));
  // R6
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(en_o));
endmodule

// File: rtl/irq_level_out.sv
module irq_level_out #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat_i & en_i);
  end

  assign irq_o = irq_q;

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & en_i)) |=> irq_o);
  // R9
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/link_irq_regs.sv
module link_irq_regs
  import link_irq_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h0C,
  parameter logic [ADDR_W-1:0] EN_OFS   = 'h0D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tx_done_i,
  input  logic              tx_done_req_i,
  input  logic              rx_done_i,
  input  logic              tx_under_i,
  input  logic              rx_over_i,
  input  logic              gap_rcv_i,
  output logic              irq_o
);
  src_vec_t ev, clr, stat, en;
  logic     stat_sel, en_sel;

  assign stat_sel = (addr_i == STAT_OFS);
  assign en_sel   = (addr_i == EN_OFS);

  always_comb begin
    ev            = '0;
    ev[SRC_GAP]   = gap_rcv_i;
    ev[SRC_RXOVR] = rx_over_i;
    ev[SRC_TXUND] = tx_under_i;
    ev[SRC_RXDN]  = rx_done_i;
    ev[SRC_TXDN]  = tx_done_i & tx_done_req_i;  // only when the slot asked
  end

  assign clr = (wr_en_i && stat_sel) ? wdata_i[REG_W-1:SRC_LSB] : '0;

  irq_sticky_status #(.N(NUM_SRC)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ev),
    .clr_i (clr),
    .stat_o(stat)
  );

  irq_enable_bank #(.N(NUM_SRC)) u_enable (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(wr_en_i && en_sel),
    .data_i(wdata_i[REG_W-1:SRC_LSB]),
    .en_o  (en)
  );

  irq_level_out #(.N(NUM_SRC)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(stat),
    .en_i  (en),
    .irq_o (irq_o)
  );

  always_comb begin
    if (stat_sel)    rdata_o = {stat, PAD_ONES};
    else if (en_sel) rdata_o = {en, PAD_ONES};
    else             rdata_o = '0;
  end

  // R8
  txdone_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_done_req_i && !stat[SRC_TXDN]) |=> !stat[SRC_TXDN]);
  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stat_sel && !en_sel) |=> $stable(en));
endmodule

// File: tb/link_irq_regs_tb_top.sv
`timescale 1ns/1ps
module link_irq_regs_tb_top;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          tx_done = 0, tx_req = 0, rx_done = 0, tx_under = 0, rx_over = 0, gap = 0;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [7:0] exp_rd;
    logic       exp_irq;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  link_irq_regs #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_done_i(tx_done),
    .tx_done_req_i(tx_req), .rx_done_i(rx_done), .tx_under_i(tx_under),
    .rx_over_i(rx_over), .gap_rcv_i(gap), .irq_o(irq)
  );

  // monitor: samples 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp_rd) begin
          errors++;
          $display("FAIL %s: rdata %h expected %h", it.tag, rdata, it.exp_rd);
        end
        checks++;
        if (irq !== it.exp_irq) begin
          errors++;
          $display("FAIL %s: irq %b expected %b", it.tag, irq, it.exp_irq);
        end
      end
    end
  end

  // all tasks start and end right at a falling edge
  task automatic chk(input logic [AW-1:0] a, input logic [7:0] e, input logic ei, input string tag);
    item_t it;
    addr = a;
    it.tag = tag; it.exp_rd = e; it.exp_irq = ei;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  // bits: {txdone, txreq, rxdone, txunder, rxover, gap}
  task automatic pulse(input logic [5:0] v);
    {tx_done, tx_req, rx_done, tx_under, rx_over, gap} = v;
    @(negedge clk);
    {tx_done, tx_req, rx_done, tx_under, rx_over, gap} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk('hC, 8'h07, 0, "R1 status reset");
    chk('hD, 8'h07, 0, "R1 enable reset");
    // R2 bit positions
    pulse(6'b000001); chk('hC, 8'h0F, 0, "R2 gap bit3");
    pulse(6'b000010); chk('hC, 8'h1F, 0, "R2 rxover bit4");
    pulse(6'b000100); chk('hC, 8'h3F, 0, "R2 txunder bit5");
    pulse(6'b001000); chk('hC, 8'h7F, 0, "R2 rxdone bit6");
    pulse(6'b110000); chk('hC, 8'hFF, 0, "R2 txdone bit7");
    // R3
    idle(20); chk('hC, 8'hFF, 0, "R3 sticky");
    // R4 / R7
    wr('hC, 8'h00); chk('hC, 8'hFF, 0, "R4 write zero keeps");
    wr('hC, 8'h07); chk('hC, 8'hFF, 0, "R7 low bits write");
    wr('hC, 8'h80); chk('hC, 8'h7F, 0, "R4 clear bit7");
    wr('hC, 8'h78); chk('hC, 8'h07, 0, "R4 clear rest");
    // R8
    pulse(6'b100000); chk('hC, 8'h07, 0, "R8 txdone no request");
    pulse(6'b010000); chk('hC, 8'h07, 0, "R8 request alone");
    pulse(6'b110000); chk('hC, 8'h87, 0, "R8 txdone with request");
    wr('hC, 8'h80); chk('hC, 8'h07, 0, "R4 clear txdone");
    // R6 / R7
    wr('hD, 8'hA8); chk('hD, 8'hAF, 0, "R6 enable A8");
    wr('hD, 8'h00); chk('hD, 8'h07, 0, "R7 enable zero");
    wr('hD, 8'hFF); chk('hD, 8'hFF, 0, "R6 enable all");
    // R9 rise and fall via clear
    pulse(6'b001000);
    chk('hC, 8'h47, 0, "R9 irq lag");
    chk('hC, 8'h47, 1, "R9 irq rise");
    wr('hC, 8'h40);
    chk('hC, 8'h07, 1, "R9 irq falls late");
    chk('hC, 8'h07, 0, "R9 irq low");
    // R9 masking
    wr('hD, 8'h08);
    pulse(6'b000010);
    idle(2); chk('hC, 8'h17, 0, "R9 masked source");
    pulse(6'b000001);
    chk('hC, 8'h1F, 0, "R9 enabled lag");
    chk('hC, 8'h1F, 1, "R9 enabled rise");
    wr('hD, 8'h00);
    chk('hD, 8'h07, 1, "R9 disable lag");
    chk('hD, 8'h07, 0, "R9 disable fall");
    wr('hC, 8'hF8); chk('hC, 8'h07, 0, "R4 clear all");
    // R5
    pulse(6'b000100); chk('hC, 8'h27, 0, "R5 pre-set");
    tx_under = 1'b1;
    wr('hC, 8'h20);
    tx_under = 1'b0;
    chk('hC, 8'h27, 0, "R5 event beats clear");
    wr('hC, 8'h20); chk('hC, 8'h07, 0, "R5 later clear");
    // R10
    wr('hE, 8'hFF); chk('hD, 8'h07, 0, "R10 enable untouched");
    chk('hC, 8'h07, 0, "R10 status untouched");
    chk('hE, 8'h00, 0, "R10 unmapped read");
    wr('h1F, 8'hF8); chk('hD, 8'h07, 0, "R10 enable untouched 1F");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done %b expected 1", done);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule